// File: doc/BRIEF.md
# Serial SPI SRAM Slave

This block is a synthesizable model of a byte-addressed serial SRAM that answers SPI mode 0 transactions (clock idles low, data sampled on the rising edge of SCK and changed on the falling edge). The device does nothing while chip-select is high. After chip-select falls, the master shifts in one command byte and then three address bytes, most significant byte first. The device then either stores each following byte at consecutive locations, or returns the contents of consecutive locations on its serial output while the master shifts in dummy bytes. The operation continues for as long as chip-select stays low, and raising chip-select ends it at any bit.

The SPI pins are sampled in the `clk` domain. They must already be synchronous to `clk`, and each SCK level must last at least one `clk` period. The storage array holds `2**ADDR_BITS` bytes. With `ADDR_BITS = 17` this is the 128 KiB part. The default is 11 (2 KiB), which keeps elaboration small. Address bits above `ADDR_BITS` in the 24-bit address are ignored. The serial output is given as a data pin plus an output-enable pin, so the pad ring can build the tri-state driver.

Top module: `spi_sram_slave`

## Requirements
- R1: While `cs_n` is high, `miso_oe` and `miso` are 0 and SCK/MOSI activity changes no stored byte.
- R2: Command byte 0x02, followed by a 3-byte address sent MSB first, stores every following complete data byte at consecutive addresses starting at that address.
- R3: Command byte 0x03, followed by a 3-byte address, returns the byte at each consecutive address, MSB first. `miso` changes only after a falling SCK edge. Bit 7 of the first byte is valid one `clk` cycle after the rising SCK edge of the last address bit.
- R4: The address increments after each data byte and wraps from `2**ADDR_BITS-1` to 0, for both writes and reads.
- R5: Address bits above `ADDR_BITS` of the 24-bit address are ignored.
- R6: Any command byte other than 0x02 or 0x03 makes the device ignore the rest of the transaction. `miso_oe` and `miso` stay 0 and no byte is stored until `cs_n` rises.
- R7: Raising `cs_n` ends the operation at any bit. A partly shifted data byte is discarded, and the next transaction starts again with a command byte.
- R8: `miso_oe` is 1 only while `cs_n` is low and a read has reached its data phase. It rises only one `clk` cycle after a rising SCK edge, and it falls as soon as `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip-select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, 0 when not driven |
| miso_oe | output | 1 | Output enable for the `miso` pad |

## Verification
Every SPI edge takes effect one `clk` cycle after the cycle in which the new SCK level is first sampled. The bench holds each SCK level for two `clk` periods, and it reads `miso` on the falling `clk` edge just before it raises SCK, which is the moment a mode 0 master samples. The R3 timing check reads `miso` and `miso_oe` one `clk` period after the rising edge of the last address bit. The checks that writes and ignored stimulus leave memory alone read the affected locations back in a later transaction, because stored contents only become visible through a read.

// File: rtl/spi_sram_slave.sv
module spi_sram_slave #(
  parameter int ADDR_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic mosi,
  output logic miso,
  output logic miso_oe
);
  localparam int DEPTH = 1 << ADDR_BITS;

  typedef enum logic [2:0] {ST_CMD, ST_ADDR, ST_WR, ST_RD, ST_SKIP} st_t;

  logic [7:0]           mem [DEPTH];
  st_t                  st;
  logic                 sck_d;
  logic [2:0]           bitc;
  logic [6:0]           sh;
  logic [1:0]           abyte;
  logic                 rd_sel;
  logic                 miso_q;
  logic [ADDR_BITS-1:0] addr;

  wire                   rise    = sck & ~sck_d;
  wire                   fall    = ~sck & sck_d;
  wire [7:0]             byte_in = {sh, mosi};
  wire                   done    = rise && (bitc == 3'd7);
  wire [ADDR_BITS+7:0]   ext     = {addr, byte_in};
  wire [ADDR_BITS-1:0]   addr_nx = ext[ADDR_BITS-1:0];

  always_ff @(posedge clk)
    if (!cs_n && done && st == ST_WR) mem[addr] <= byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_CMD;
      sck_d  <= 1'b0;
      bitc   <= '0;
      sh     <= '0;
      abyte  <= '0;
      rd_sel <= 1'b0;
      miso_q <= 1'b0;
      addr   <= '0;
    end else begin
      sck_d <= sck;
      if (cs_n) begin
        st     <= ST_CMD;
        bitc   <= '0;
        abyte  <= '0;
        miso_q <= 1'b0;
      end else begin
        if (rise) begin
          sh   <= byte_in[6:0];
          bitc <= bitc + 3'd1;
        end
        if (fall && st == ST_RD) miso_q <= mem[addr][~bitc];
        if (done) begin
          case (st)
            ST_CMD: begin
              abyte <= '0;
              if (byte_in == 8'h02) begin
                rd_sel <= 1'b0;
                st     <= ST_ADDR;
              end else if (byte_in == 8'h03) begin
                rd_sel <= 1'b1;
                st     <= ST_ADDR;
              end else begin
                st <= ST_SKIP;
              end
            end
            ST_ADDR: begin
              addr  <= addr_nx;
              abyte <= abyte + 2'd1;
              if (abyte == 2'd2) begin
                st <= rd_sel ? ST_RD : ST_WR;
                if (rd_sel) miso_q <= mem[addr_nx][7];
              end
            end
            ST_WR, ST_RD: addr <= addr + 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

  assign miso_oe = ~cs_n & (st == ST_RD);
  assign miso    = miso_oe & miso_q;
endmodule

module spi_sram_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sck,
  input logic miso,
  input logic miso_oe
);
  logic sck_p;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_p <= 1'b0;
    else        sck_p <= sck;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!miso_oe && !miso));

  assert_undriven_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso);

  assert_change_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(miso_oe) && miso_oe && !($past(sck_p) && !$past(sck))) |-> $stable(miso));

  assert_oe_rise_after_sck_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> ($past(sck) && !$past(sck_p)));

  assert_oe_fall_on_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(miso_oe) |-> cs_n);
endmodule

bind spi_sram_slave spi_sram_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .miso(miso), .miso_oe(miso_oe)
);

// File: tb/spi_sram_slave_test.sv
`timescale 1ns/1ps
module spi_sram_slave_test;
  localparam int AB   = 11;
  localparam int MASK = (1 << AB) - 1;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, mosi = 1'b0;
  logic miso, miso_oe;
  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;
  logic last_oe, last_miso;
  logic [7:0] model [1 << AB];
  bit         valid [1 << AB];
  logic [7:0] wbuf  [8];

  spi_sram_slave #(.ADDR_BITS(AB)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int idx(input logic [23:0] a, input int k);
    return (int'(a) + k) & MASK;
  endfunction

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk); mosi = tx[i];
      @(negedge clk); rx[i] = miso; sck = 1'b1;
      @(negedge clk); last_oe = miso_oe; last_miso = miso;
      @(negedge clk); sck = 1'b0;
    end
  endtask

  task automatic start_t();
    @(negedge clk); cs_n = 1'b0;
  endtask

  task automatic stop_t();
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_hdr(input logic [7:0] cmd, input logic [23:0] a);
    logic [7:0] r;
    xfer(cmd, 8, r); xfer(a[23:16], 8, r); xfer(a[15:8], 8, r); xfer(a[7:0], 8, r);
  endtask

  task automatic do_write(input logic [23:0] a, input int n);
    logic [7:0] r;
    start_t();
    send_hdr(8'h02, a);
    for (int k = 0; k < n; k++) begin
      xfer(wbuf[k], 8, r);
      check("R8 oe low during write", int'(last_oe), 0);
      model[idx(a, k)] = wbuf[k];
      valid[idx(a, k)] = 1'b1;
    end
    stop_t();
  endtask

  task automatic do_read(input logic [23:0] a, input int n, input string req);
    logic [7:0] r;
    start_t();
    send_hdr(8'h03, a);
    check("R3 oe after last address bit", int'(last_oe), 1);
    if (valid[idx(a, 0)])
      check("R3 first bit after last address bit", int'(last_miso), int'(model[idx(a, 0)][7]));
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, 8, r);
      if (valid[idx(a, k)]) check(req, int'(r), int'(model[idx(a, k)]));
    end
    stop_t();
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000 && !finished) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] r;
    logic [23:0] a, ra;
    int n, off;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset oe", int'(miso_oe), 0);
    check("R1 reset miso", int'(miso), 0);

    // R2 / R3: directed stream write then read
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h81; wbuf[3] = 8'h7E;
    do_write(24'h000010, 4);
    do_read(24'h000010, 4, "R2 R3 stream readback");

    // R1: SCK/MOSI activity with cs_n high
    xfer(8'h02, 8, r); check("R1 oe idle", int'(last_oe), 0); check("R1 miso idle", int'(r), 0);
    xfer(8'h00, 8, r); xfer(8'h00, 8, r); xfer(8'h10, 8, r); xfer(8'hFF, 8, r);
    check("R1 miso idle", int'(r), 0);
    do_read(24'h000010, 1, "R1 memory untouched while deselected");

    // R4: wrap at the top of the array
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(24'(MASK - 1), 3);
    do_read(24'(MASK), 2, "R4 wrap on read");
    do_read(24'h000000, 1, "R4 wrap on write landed at 0");

    // R5: upper address bits ignored
    wbuf[0] = 8'hC7;
    do_write(24'hF80020, 1);
    do_read(24'h000020, 1, "R5 upper bits ignored");
    do_read(24'h07F820, 1, "R5 upper bits ignored");

    // R6: unknown command ignores the rest
    start_t();
    xfer(8'h05, 8, r);
    check("R6 oe after bad command", int'(last_oe), 0);
    xfer(8'h02, 8, r); xfer(8'h00, 8, r); xfer(8'h00, 8, r); xfer(8'h10, 8, r);
    xfer(8'hFF, 8, r);
    check("R6 oe stays low", int'(last_oe), 0);
    check("R6 miso stays low", int'(r), 0);
    stop_t();
    do_read(24'h000010, 2, "R6 memory unchanged");

    // R7: partial byte discarded, next transaction restarts at command
    wbuf[0] = 8'h44; wbuf[1] = 8'h55;
    do_write(24'h000030, 2);
    start_t();
    send_hdr(8'h02, 24'h000030);
    xfer(8'hAA, 8, r);
    xfer(8'h99, 5, r);
    stop_t();
    model[16'h30] = 8'hAA;
    do_read(24'h000030, 2, "R7 partial byte dropped");
    start_t();
    send_hdr(8'h03, 24'h000030);
    xfer(8'h00, 3, r);
    stop_t();
    do_read(24'h000031, 1, "R7 restart after aborted read");

    // Random mixed traffic
    for (int it = 0; it < 40; it++) begin
      a = 24'($urandom);
      n = 1 + int'($urandom % 6);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      do_write(a, n);
      off = int'($urandom % n);
      ra = (24'($urandom) & ~24'(MASK)) | 24'(idx(a, off));
      do_read(ra, n - off, "R2 R3 R5 random readback");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule